// File: doc/BRIEF.md
# Masked Scalar Half-Precision Move Unit

This datapath performs a single scalar 16-bit floating-point move under the control of one mask bit. It sits after instruction decode: the caller presents the opcode byte, a flag saying whether the r/m operand is memory, the low halves of the registers named by the reg and r/m fields, the 128-bit value of the register named by the vvvv field, the 16-bit memory read data, bit 0 of the selected mask register, a no-mask flag (mask index 0) and a zeroing flag. One cycle later the unit returns the full destination vector with a write enable and a field select, or a 16-bit memory write with a strobe. It can also return an illegal-encoding flag instead.

Three forms exist. The load form brings memory data into lane 0 and clears everything above it. The store form writes lane 0 of a register to memory only when the mask allows it. The register form takes lane 0 from one register and bits 127:16 from the vvvv register. Two opcodes reach the register form, with the roles of the reg and r/m fields swapped. The move is a raw bit copy and never changes the payload.

Top module: `hmove_unit`

## Requirements
- R1: Opcode 0x10 with has_mem=1 is the load form and with has_mem=0 the register form. Opcode 0x11 with has_mem=1 is the store form and with has_mem=0 the register form. Any other opcode sets illegal=1 and issues no register or memory write.
- R2: In the register form, opcode 0x10 writes the reg-field register (dst_sel=0) from the r/m-field low half. Opcode 0x11 writes the r/m-field register (dst_sel=1) from the reg-field low half. The load form always has dst_sel=0, and the store form takes its data from the reg field.
- R3: When kmask0=1 or no_mask=1, destination bits 15:0 (or mem_wdata) equal the source's low 16 bits exactly, including NaN and denormal patterns.
- R4: When kmask0=0, no_mask=0 and zeroing=1 in the load or register form, destination bits 15:0 are 0.
- R5: When kmask0=0, no_mask=0 and zeroing=0 in the load or register form, destination bits 15:0 equal the previous low half of the destination register.
- R6: The load form drives destination bits VLEN-1:16 to 0 for every mask outcome.
- R7: The register form drives destination bits 127:16 from vvvv_val[127:16] and bits VLEN-1:128 to 0.
- R8: The store form raises mem_we only when kmask0=1 or no_mask=1. It never raises dst_we.
- R9: A store form with zeroing=1 sets illegal=1, and mem_we and dst_we both stay low.
- R10: Every accepted input (in_valid=1) yields exactly one out_valid pulse in the following cycle. All strobes and flags are low while reset is asserted and when no move completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded move is presented this cycle |
| opcode | input | 8 | Opcode byte (0x10 or 0x11) |
| has_mem | input | 1 | 1 when the r/m operand is memory |
| reg_lo | input | 16 | Low 16 bits of the reg-field register |
| rm_lo | input | 16 | Low 16 bits of the r/m-field register |
| vvvv_val | input | 128 | Low 128 bits of the vvvv-field register |
| mem_rdata | input | 16 | Memory read value for the load form |
| kmask0 | input | 1 | Bit 0 of the selected mask register |
| no_mask | input | 1 | 1 when the mask index is 0 (no masking) |
| zeroing | input | 1 | 1 selects zero-masking, 0 merge-masking |
| out_valid | output | 1 | One-cycle pulse for a completed move |
| dst_we | output | 1 | Destination register write enable |
| dst_sel | output | 1 | 0 writes the reg-field register, 1 the r/m-field register |
| dst_wdata | output | VLEN | Full destination vector |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| illegal | output | 1 | Illegal encoding; no write issued |

## Verification
The checker watches several rules on every cycle. It confirms that each accepted input produces one valid pulse a cycle later, and that a register write and a memory write never occur together. It confirms that an illegal flag suppresses both writes and that a masked-off store leaves the strobe low. It also checks the upper-bit rules of both the load form and the register form against the inputs one cycle back. The bench scenarios are what show lane 0 itself: merge against zero masking, the swapped operand roles of the two register opcodes, NaN payloads passing unchanged, and the decoding of stray opcodes.

// File: rtl/hmove_pkg.sv
package hmove_pkg;
  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_LOAD  = 2'd1,
    FORM_STORE = 2'd2,
    FORM_REG   = 2'd3
  } form_e;

  localparam logic [7:0] OPC_INTO_REG = 8'h10;
  localparam logic [7:0] OPC_FROM_REG = 8'h11;
endpackage

// File: rtl/hmove_decode.sv
module hmove_decode
  import hmove_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       has_mem,
  input  logic       zeroing,
  output form_e      form,
  output logic       dst_is_rm,
  output logic       illegal
);
  always_comb begin
    form      = FORM_NONE;
    dst_is_rm = 1'b0;
    illegal   = 1'b0;
    unique case (opcode)
      OPC_INTO_REG: form = has_mem ? FORM_LOAD : FORM_REG;
      OPC_FROM_REG: begin
        form      = has_mem ? FORM_STORE : FORM_REG;
        dst_is_rm = ~has_mem;
      end
      default: illegal = 1'b1;
    endcase
    if (form == FORM_STORE && zeroing) illegal = 1'b1;
  end
endmodule

// File: rtl/hmove_lane0.sv
module hmove_lane0 #(
  parameter int ELEM_W = 16
) (
  input  logic [ELEM_W-1:0] src,
  input  logic [ELEM_W-1:0] prev,
  input  logic              lane_en,
  input  logic              zeroing,
  output logic [ELEM_W-1:0] res
);
  always_comb begin
    if (lane_en)      res = src;
    else if (zeroing) res = '0;
    else              res = prev;
  end
endmodule

// File: rtl/hmove_upper.sv
module hmove_upper
  import hmove_pkg::*;
#(
  parameter int VLEN   = 512,
  parameter int XMM_W  = 128,
  parameter int ELEM_W = 16
) (
  input  form_e                  form,
  input  logic [XMM_W-1:0]       vvvv_val,
  output logic [VLEN-1:ELEM_W]   upper
);
  logic [XMM_W-1:ELEM_W] mid;

  always_comb begin
    mid = (form == FORM_REG) ? vvvv_val[XMM_W-1:ELEM_W] : '0;
  end

  generate
    if (VLEN > XMM_W) begin : g_wide
      assign upper = {{(VLEN-XMM_W){1'b0}}, mid};
    end else begin : g_narrow
      assign upper = mid;
    end
  endgenerate
endmodule

// File: rtl/hmove_unit.sv
module hmove_unit
  import hmove_pkg::*;
#(
  parameter int VLEN   = 512,
  parameter int XMM_W  = 128,
  parameter int ELEM_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         opcode,
  input  logic               has_mem,
  input  logic [ELEM_W-1:0]  reg_lo,
  input  logic [ELEM_W-1:0]  rm_lo,
  input  logic [XMM_W-1:0]   vvvv_val,
  input  logic [ELEM_W-1:0]  mem_rdata,
  input  logic               kmask0,
  input  logic               no_mask,
  input  logic               zeroing,
  output logic               out_valid,
  output logic               dst_we,
  output logic               dst_sel,
  output logic [VLEN-1:0]    dst_wdata,
  output logic               mem_we,
  output logic [ELEM_W-1:0]  mem_wdata,
  output logic               illegal
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  form_e               form;
  logic                dst_is_rm;
  logic                bad_enc;
  logic                lane_en;
  logic [ELEM_W-1:0]   src_low;
  logic [ELEM_W-1:0]   prev_low;
  logic [ELEM_W-1:0]   lane_res;
  logic [VLEN-1:ELEM_W] upper;

  hmove_decode u_decode (
    .opcode    (opcode),
    .has_mem   (has_mem),
    .zeroing   (zeroing),
    .form      (form),
    .dst_is_rm (dst_is_rm),
    .illegal   (bad_enc)
  );

  assign lane_en = no_mask | kmask0;

  always_comb begin
    prev_low = dst_is_rm ? rm_lo : reg_lo;
    unique case (form)
      FORM_LOAD:  src_low = mem_rdata;
      FORM_REG:   src_low = dst_is_rm ? reg_lo : rm_lo;
      default:    src_low = reg_lo;
    endcase
  end

  hmove_lane0 #(.ELEM_W(ELEM_W)) u_lane0 (
    .src     (src_low),
    .prev    (prev_low),
    .lane_en (lane_en),
    .zeroing (zeroing),
    .res     (lane_res)
  );

  hmove_upper #(.VLEN(VLEN), .XMM_W(XMM_W), .ELEM_W(ELEM_W)) u_upper (
    .form     (form),
    .vvvv_val (vvvv_val),
    .upper    (upper)
  );

  // next-state
  logic              valid_n, dst_we_n, mem_we_n, illegal_n;
  logic [VLEN-1:0]   dst_data_n;

  always_comb begin
    valid_n    = in_valid;
    illegal_n  = in_valid & bad_enc;
    dst_we_n   = in_valid & ~bad_enc & ((form == FORM_LOAD) | (form == FORM_REG));
    mem_we_n   = in_valid & ~bad_enc & (form == FORM_STORE) & lane_en;
    dst_data_n = {upper, lane_res};
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      dst_we    <= 1'b0;
      mem_we    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= valid_n;
      dst_we    <= dst_we_n;
      mem_we    <= mem_we_n;
      illegal   <= illegal_n;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      dst_wdata <= dst_data_n;
      dst_sel   <= dst_is_rm;
      mem_wdata <= src_low;
    end
  end
endmodule

// File: rtl/hmove_checker.sv
module hmove_checker #(
  parameter int VLEN   = 512,
  parameter int XMM_W  = 128,
  parameter int ELEM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic              has_mem,
  input logic [XMM_W-1:0]  vvvv_val,
  input logic              kmask0,
  input logic              no_mask,
  input logic              zeroing,
  input logic              out_valid,
  input logic              dst_we,
  input logic [VLEN-1:0]   dst_wdata,
  input logic              mem_we,
  input logic              illegal
);
  // R10: one pulse per accepted input, one cycle later
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R1 / R9: illegal suppresses both writes; writes never coincide
  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!dst_we && !mem_we));
  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_we && mem_we));

  // R8: store with mask bit clear never strobes memory
  assert_store_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && has_mem && opcode == 8'h11 && !no_mask && !kmask0) |=> !mem_we);

  // R9: store with zeroing flagged
  assert_store_zero_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && has_mem && opcode == 8'h11 && zeroing) |=> illegal);

  // R6: load clears the upper bits
  assert_load_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && has_mem && opcode == 8'h10)
      |=> (dst_we && dst_wdata[VLEN-1:ELEM_W] == '0));

  // R7: register form copies 127:16 from vvvv
  assert_reg_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !has_mem && (opcode == 8'h10 || opcode == 8'h11))
      |=> (dst_we && dst_wdata[XMM_W-1:ELEM_W] == $past(vvvv_val[XMM_W-1:ELEM_W])));
endmodule

bind hmove_unit hmove_checker #(.VLEN(VLEN), .XMM_W(XMM_W), .ELEM_W(ELEM_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .has_mem   (has_mem),
  .vvvv_val  (vvvv_val),
  .kmask0    (kmask0),
  .no_mask   (no_mask),
  .zeroing   (zeroing),
  .out_valid (out_valid),
  .dst_we    (dst_we),
  .dst_wdata (dst_wdata),
  .mem_we    (mem_we),
  .illegal   (illegal)
);

// File: tb/hmove_unit_bench.sv
module hmove_unit_bench;
  localparam int VLEN = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              in_valid = 1'b0;
  logic [7:0]        opcode = 8'h00;
  logic              has_mem = 1'b0;
  logic [15:0]       reg_lo = '0, rm_lo = '0, mem_rdata = '0;
  logic [127:0]      vvvv_val = '0;
  logic              kmask0 = 1'b0, no_mask = 1'b0, zeroing = 1'b0;
  logic              out_valid, dst_we, dst_sel, mem_we, illegal;
  logic [VLEN-1:0]   dst_wdata;
  logic [15:0]       mem_wdata;

  hmove_unit #(.VLEN(VLEN)) u_hmove_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .has_mem(has_mem), .reg_lo(reg_lo), .rm_lo(rm_lo), .vvvv_val(vvvv_val),
    .mem_rdata(mem_rdata), .kmask0(kmask0), .no_mask(no_mask),
    .zeroing(zeroing), .out_valid(out_valid), .dst_we(dst_we),
    .dst_sel(dst_sel), .dst_wdata(dst_wdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .illegal(illegal)
  );

  typedef struct {
    logic            dst_we, dst_sel, mem_we, illegal;
    logic [VLEN-1:0] dst_data;
    logic [15:0]     mem_data;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  int   pushed = 0;
  int   seen = 0;

  task automatic check(input bit ok, input string tag, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected result built from the requirements
  task automatic drive(input string tag, input logic [7:0] op, input logic mem,
                       input logic [15:0] r, input logic [15:0] m,
                       input logic [127:0] v, input logic [15:0] md,
                       input logic k, input logic nm, input logic z);
    exp_t e;
    logic en;
    logic [15:0] src, prev;
    en = k | nm;
    e.tag = tag;
    e.dst_we = 0; e.mem_we = 0; e.illegal = 0; e.dst_sel = 0;
    e.dst_data = '0; e.mem_data = r;
    if (op != 8'h10 && op != 8'h11) e.illegal = 1;               // R1
    else if (op == 8'h11 && mem) begin                            // store
      if (z) e.illegal = 1;                                       // R9
      else e.mem_we = en;                                         // R8
    end else begin
      e.dst_we = 1;
      e.dst_sel = (op == 8'h11);                                  // R2
      src  = mem ? md : (e.dst_sel ? r : m);
      prev = e.dst_sel ? m : r;
      if (!mem) e.dst_data[127:16] = v[127:16];                   // R7
      e.dst_data[15:0] = en ? src : (z ? 16'h0 : prev);           // R3 R4 R5
    end
    @(negedge clk);
    in_valid = 1; opcode = op; has_mem = mem; reg_lo = r; rm_lo = m;
    vvvv_val = v; mem_rdata = md; kmask0 = k; no_mask = nm; zeroing = z;
    exp_q.push_back(e);
    pushed++;
    @(negedge clk);
    in_valid = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && out_valid) begin
        exp_t e;
        seen++;
        if (exp_q.size() == 0) check(0, "R10 unexpected out_valid", 1, 0);
        else begin
          e = exp_q.pop_front();
          check(illegal == e.illegal, {e.tag, " illegal"}, illegal, e.illegal);
          check(dst_we == e.dst_we, {e.tag, " dst_we"}, dst_we, e.dst_we);
          check(mem_we == e.mem_we, {e.tag, " mem_we"}, mem_we, e.mem_we);
          if (e.dst_we) begin
            check(dst_sel == e.dst_sel, {e.tag, " dst_sel"}, dst_sel, e.dst_sel);
            check(dst_wdata === e.dst_data, {e.tag, " dst_wdata"}, dst_wdata, e.dst_data);
          end
          if (e.mem_we)
            check(mem_wdata === e.mem_data, {e.tag, " mem_wdata"}, mem_wdata, e.mem_data);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [127:0] V1 = 128'hA5A5_1234_5678_9ABC_DEF0_0F0F_F0F0_C3C3;

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !dst_we && !mem_we && !illegal, "R10 reset state",
          {out_valid, dst_we, mem_we, illegal}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!out_valid, "R10 idle after reset", out_valid, 0);

    // load forms
    drive("R3 R6 load unmasked NaN", 8'h10, 1, 16'h1111, 16'h2222, V1, 16'h7E01, 1, 0, 0);
    drive("R3 load no_mask", 8'h10, 1, 16'h1111, 16'h2222, V1, 16'h8001, 0, 1, 0);
    drive("R5 R6 load merge", 8'h10, 1, 16'hBEEF, 16'h2222, V1, 16'h7C00, 0, 0, 0);
    drive("R4 R6 load zero", 8'h10, 1, 16'hBEEF, 16'h2222, V1, 16'h7C00, 0, 0, 1);
    // register forms
    drive("R2 R7 reg op10", 8'h10, 0, 16'h1111, 16'hFC01, V1, 16'h0, 1, 0, 0);
    drive("R2 R7 reg op11 swapped", 8'h11, 0, 16'h0003, 16'h4444, V1, 16'h0, 1, 0, 1);
    drive("R5 reg op11 merge keeps rm", 8'h11, 0, 16'h0003, 16'h4444, ~V1, 16'h0, 0, 0, 0);
    drive("R4 reg op10 zero", 8'h10, 0, 16'h5555, 16'h6666, V1, 16'h0, 0, 0, 1);
    // store forms
    drive("R8 store enabled", 8'h11, 1, 16'hFFFF, 16'h1234, V1, 16'h0, 1, 0, 0);
    drive("R8 store masked off", 8'h11, 1, 16'h7777, 16'h1234, V1, 16'h0, 0, 0, 0);
    drive("R3 R8 store no_mask", 8'h11, 1, 16'h0400, 16'h1234, V1, 16'h0, 0, 1, 0);
    drive("R9 store zeroing", 8'h11, 1, 16'h0400, 16'h1234, V1, 16'h0, 1, 0, 1);
    // bad opcodes
    drive("R1 opcode 12", 8'h12, 0, 16'h1, 16'h2, V1, 16'h0, 1, 0, 0);
    drive("R1 opcode 00 mem", 8'h00, 1, 16'h1, 16'h2, V1, 16'h0, 1, 1, 0);

    repeat (3) @(negedge clk);
    check(!out_valid && !dst_we && !mem_we, "R10 idle strobes low",
          {out_valid, dst_we, mem_we}, 0);
    check(seen == pushed && exp_q.size() == 0, "R10 pulse count", seen, pushed);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule